// File: doc/BRIEF.md
# Four-Lane Systolic Multiply-Accumulate Array

This block evaluates one neural layer for four input patterns at the same time. The layer's matrix/vector product becomes a matrix/matrix product. A single input stream carries one signed 16-bit activity and one signed 16-bit weight per beat. Four processing lanes share that stream. Each lane computes one output neuron and keeps a separate 40-bit accumulator for each of the four patterns. Because every weight is reused against four activities, one weight per beat keeps all four lanes busy.

The stream is organised in groups of four beats, one group per input index j. Beat t of a group carries pattern t's activity for input j and lane t's weight for input j. Activities move from lane to lane through registers, so lane k sees a beat k accepted beats later. Lane k loads its weight on beat k of a group and holds it for the four activities that then pass it. Each lane is a three-step pipeline: operand preparation (with an optional subtraction), multiplication, and accumulation. The per-beat mode flag selects either multiply-accumulate (activity times weight) or squared-difference accumulate ((activity minus weight) squared), which is used for distance-based networks. A first marker starts a neuron set from a per-lane bias. A last marker closes the set.

Input back-pressure rules: a beat transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops after the final beat of a closing group and stays low while the pipeline empties and the sixteen results drain. The sender keeps its beat stable while `in_ready` is low. Output rules: a result transfers when `out_valid` and `out_ready` are both high. While `out_ready` is low, the result and its tags stay unchanged.

Top module: `sysmac_array`

## Requirements
- R1: After reset, `in_ready` is high and `out_valid` is low.
- R2: The beat position within a group counts accepted beats modulo 4 and starts at 0 after reset and after each drain. On beat t, `in_act` is pattern t's activity and `in_wgt` is lane t's weight for the current input index.
- R3: In multiply-accumulate mode (`in_sq` low), the term added to lane k, pattern p for input j is the signed product of pattern p's activity and lane k's weight. All values are 16-bit two's complement, and the product is sign-extended to 40 bits.
- R4: When `in_sq` is high on the beat that carries pattern p's activity, the term for every lane for that pattern and input is (activity minus weight) squared, which is never negative. Modes may differ between beats.
- R5: When `in_first` is high on beat k of a group, lane k starts every pattern accumulator from `in_bias` (sign-extended to 40 bits) plus the first term. Any earlier content is discarded.
- R6: Accepting beat 3 of a group with `in_last` high ends the set. After the pipeline empties, the block emits 16 results: lane 0 patterns 0 to 3 first, then lane 1, and so on. The first result has `out_lane` and `out_pat` both 0.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_lane` and `out_pat` hold.
- R8: Accumulation wraps modulo 2^40 in two's complement, with no saturation.
- R9: After the last result transfers, all accumulators are cleared. A following set without a first marker starts from zero.
- R10: Idle cycles on the input (`in_valid` low) and on the output (`out_ready` low) do not change any result.
- R11: While results are pending, `in_ready` is low and offered beats are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_act | input | 16 | Signed activity of pattern t |
| in_wgt | input | 16 | Signed weight for lane t |
| in_bias | input | 16 | Signed bias for lane t, used with the first marker |
| in_first | input | 1 | Group is the first input of a neuron set |
| in_last | input | 1 | Group is the last input of a neuron set |
| in_sq | input | 1 | Squared-difference mode for this beat |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Result can be taken |
| out_data | output | 40 | Accumulated sum |
| out_lane | output | 2 | Lane (neuron) index of the result |
| out_pat | output | 2 | Pattern index of the result |

## Verification
A short set of hand-picked values separates lane/pattern mix-ups, because each cross product is distinct. Random multiply-accumulate sets with bias expose errors in weight staggering and pattern tagging. Mixed-mode sets with random input gaps and output stalls show whether the mode follows the activity and whether stalls leak into the pipeline. A set without the first marker after a drain checks the clear. A 130-input set of extreme squared differences forces the 40-bit wrap, and a single-input set with the most negative operands tests the product's sign extension.

// File: rtl/sysmac_pkg.sv
package sysmac_pkg;
  localparam int unsigned SM_DW    = 16;
  localparam int unsigned SM_AW    = 40;
  localparam int unsigned SM_LANES = 4;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sysmac_seq.sv
module sysmac_seq
  import sysmac_pkg::*;
#(
  parameter int unsigned LANES     = SM_LANES,
  parameter int unsigned PW        = $clog2(LANES),
  parameter int unsigned FLUSH_LEN = LANES + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          advance,
  output logic [PW-1:0] beat_tag,
  output logic          out_valid,
  output logic [PW-1:0] rd_lane,
  output logic [PW-1:0] rd_pat,
  output logic          acc_clr
);
  localparam int unsigned FCW     = $clog2(FLUSH_LEN + 1);
  localparam int unsigned IW      = 2 * PW;
  localparam logic [IW-1:0] LASTIDX = IW'(LANES * LANES - 1);

  seq_state_e    state;
  logic [FCW-1:0] fcnt;
  logic [IW-1:0]  ridx;
  logic           accept;

  assign in_ready  = (state == ST_RUN);
  assign out_valid = (state == ST_DRAIN);
  assign accept    = in_valid && in_ready;
  assign advance   = accept || (state == ST_FLUSH);
  assign rd_lane   = ridx[IW-1:PW];
  assign rd_pat    = ridx[PW-1:0];
  assign acc_clr   = out_valid && out_ready && (ridx == LASTIDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      beat_tag <= '0;
      fcnt     <= '0;
      ridx     <= '0;
    end else begin
      case (state)
        ST_RUN: if (accept) begin
          beat_tag <= (beat_tag == PW'(LANES - 1)) ? '0 : beat_tag + 1'b1;
          if (beat_tag == PW'(LANES - 1) && in_last) begin
            state <= ST_FLUSH;
            fcnt  <= '0;
          end
        end
        ST_FLUSH: begin
          fcnt <= fcnt + 1'b1;
          if (fcnt == FCW'(FLUSH_LEN - 1)) begin
            state <= ST_DRAIN;
            ridx  <= '0;
          end
        end
        ST_DRAIN: if (out_ready) begin
          if (ridx == LASTIDX) begin
            state    <= ST_RUN;
            beat_tag <= '0;
          end else begin
            ridx <= ridx + 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // R2: a set closes only on a group boundary, so the beat position is back at 0
  assert_tag_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |-> (beat_tag == '0));
endmodule

// File: rtl/sysmac_pe.sv
module sysmac_pe
  import sysmac_pkg::*;
#(
  parameter int unsigned DW    = SM_DW,
  parameter int unsigned AW    = SM_AW,
  parameter int unsigned LANES = SM_LANES,
  parameter int unsigned PW    = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          load,
  input  logic          first_in,
  input  logic [DW-1:0] bias_in,
  input  logic [DW-1:0] wgt_in,
  input  logic [DW-1:0] act,
  input  logic          act_valid,
  input  logic [PW-1:0] act_tag,
  input  logic          act_sq,
  input  logic          acc_clr,
  input  logic [PW-1:0] rd_pat,
  output logic [AW-1:0] rd_data
);
  localparam int unsigned OW = DW + 1;
  localparam int unsigned MW = 2 * OW;

  logic [DW-1:0] w_q, b_q, w_use, b_use;
  logic          f_q, f_use;

  logic                 s1_v, s1_first, s1_sq;
  logic [PW-1:0]        s1_tag;
  logic [DW-1:0]        s1_bias;
  logic signed [OW-1:0] s1_a, s1_b;
  logic signed [OW-1:0] act_x, wgt_x, diff;
  logic signed [MW-1:0] mul;

  logic          s2_v, s2_first, s2_sq;
  logic [PW-1:0] s2_tag;
  logic [DW-1:0] s2_bias;
  logic [AW-1:0] s2_prod;
  logic [AW-1:0] acc [LANES];

  // weight, bias and first flag are taken on this lane's beat of the group
  assign w_use = load ? wgt_in   : w_q;
  assign b_use = load ? bias_in  : b_q;
  assign f_use = load ? first_in : f_q;

  assign act_x = $signed({act[DW-1], act});
  assign wgt_x = $signed({w_use[DW-1], w_use});
  assign diff  = act_x - wgt_x;
  assign mul   = s1_a * s1_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q <= '0; b_q <= '0; f_q <= 1'b0;
      s1_v <= 1'b0; s1_first <= 1'b0; s1_sq <= 1'b0; s1_tag <= '0;
      s1_bias <= '0; s1_a <= '0; s1_b <= '0;
      s2_v <= 1'b0; s2_first <= 1'b0; s2_sq <= 1'b0; s2_tag <= '0;
      s2_bias <= '0; s2_prod <= '0;
    end else if (advance) begin
      if (load) begin
        w_q <= wgt_in; b_q <= bias_in; f_q <= first_in;
      end
      s1_v     <= act_valid;
      s1_tag   <= act_tag;
      s1_first <= f_use;
      s1_bias  <= b_use;
      s1_sq    <= act_sq;
      s1_a     <= act_sq ? diff : act_x;
      s1_b     <= act_sq ? diff : wgt_x;
      s2_v     <= s1_v;
      s2_tag   <= s1_tag;
      s2_first <= s1_first;
      s2_bias  <= s1_bias;
      s2_sq    <= s1_sq;
      s2_prod  <= {{(AW-MW){mul[MW-1]}}, mul};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || acc_clr) begin
      for (int i = 0; i < LANES; i++) acc[i] <= '0;
    end else if (advance && s2_v) begin
      acc[s2_tag] <= (s2_first ? {{(AW-DW){s2_bias[DW-1]}}, s2_bias} : acc[s2_tag])
                     + s2_prod;
    end
  end

  assign rd_data = acc[rd_pat];

  // R4: a squared difference never enters the adder as a negative term
  assert_sq_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && s2_sq) |-> !s2_prod[AW-1]);

  for (genvar g = 0; g < LANES; g++) begin : g_clr_chk
    // R9: drain end leaves every accumulator at zero
    assert_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clr |=> (acc[g] == '0));
  end
endmodule

// File: rtl/sysmac_array.sv
module sysmac_array
  import sysmac_pkg::*;
#(
  parameter int unsigned DW    = SM_DW,
  parameter int unsigned AW    = SM_AW,
  parameter int unsigned LANES = SM_LANES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DW-1:0]            in_act,
  input  logic [DW-1:0]            in_wgt,
  input  logic [DW-1:0]            in_bias,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic                     in_sq,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [AW-1:0]            out_data,
  output logic [$clog2(LANES)-1:0] out_lane,
  output logic [$clog2(LANES)-1:0] out_pat
);
  localparam int unsigned PW = $clog2(LANES);

  logic          advance, accept, acc_clr;
  logic [PW-1:0] beat_tag, rd_lane, rd_pat;
  logic [LANES-1:0][AW-1:0] rd_all;

  assign accept = in_valid && in_ready;

  sysmac_seq #(.LANES(LANES), .PW(PW), .FLUSH_LEN(LANES + 1)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .out_ready(out_ready), .in_ready(in_ready), .advance(advance),
    .beat_tag(beat_tag), .out_valid(out_valid), .rd_lane(rd_lane),
    .rd_pat(rd_pat), .acc_clr(acc_clr)
  );

  for (genvar k = 0; k < LANES; k++) begin : lane
    logic [DW-1:0] pe_act;
    logic          pe_v, pe_sq;
    logic [PW-1:0] pe_tag;

    if (k == 0) begin : g_head
      assign pe_act = in_act;
      assign pe_v   = accept;
      assign pe_tag = beat_tag;
      assign pe_sq  = in_sq;
    end else begin : g_link
      logic [DW-1:0] act_q;
      logic          v_q, sq_q;
      logic [PW-1:0] tag_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          act_q <= '0; v_q <= 1'b0; sq_q <= 1'b0; tag_q <= '0;
        end else if (advance) begin
          act_q <= lane[k-1].pe_act;
          v_q   <= lane[k-1].pe_v;
          sq_q  <= lane[k-1].pe_sq;
          tag_q <= lane[k-1].pe_tag;
        end
      end
      assign pe_act = act_q;
      assign pe_v   = v_q;
      assign pe_tag = tag_q;
      assign pe_sq  = sq_q;
    end

    sysmac_pe #(.DW(DW), .AW(AW), .LANES(LANES), .PW(PW)) u_pe (
      .clk(clk), .rst_n(rst_n), .advance(advance),
      .load(accept && (beat_tag == PW'(k))),
      .first_in(in_first), .bias_in(in_bias), .wgt_in(in_wgt),
      .act(pe_act), .act_valid(pe_v), .act_tag(pe_tag), .act_sq(pe_sq),
      .acc_clr(acc_clr), .rd_pat(rd_pat), .rd_data(rd_all[k])
    );
  end

  assign out_data = rd_all[rd_lane];
  assign out_lane = rd_lane;
  assign out_pat  = rd_pat;

  // R7: a stalled result holds
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_lane) && $stable(out_pat)));
  // R6: every drain starts at lane 0, pattern 0
  assert_drain_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_lane == '0 && out_pat == '0));
  // R11: no beat is taken while a result is offered
  assert_no_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !accept);
endmodule

// File: tb/tb_sysmac_array.sv
module tb_sysmac_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_sq = 1'b0;
  logic [15:0] in_act = '0, in_wgt = '0, in_bias = '0;
  logic        in_ready, out_valid;
  logic        out_ready = 1'b0;
  logic [39:0] out_data;
  logic [1:0]  out_lane, out_pat;

  sysmac_array dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_act(in_act), .in_wgt(in_wgt), .in_bias(in_bias), .in_first(in_first),
    .in_last(in_last), .in_sq(in_sq), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_lane(out_lane), .out_pat(out_pat)
  );

  always #5 clk = ~clk;

  int  total = 0, bad = 0, cyc = 0;
  bit  done = 0;
  int  sa [200][4];
  int  sw [4][200];
  int  sb [4];
  bit  ssq [200][4];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act_v, input longint exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic int rnd16();
    logic [15:0] v = 16'($urandom);
    return int'($signed(v));
  endfunction

  function automatic logic [39:0] expect_val(int n, bit uf, int k, int p);
    logic [39:0] acc = uf ? 40'(longint'(sb[k])) : 40'd0;
    for (int j = 0; j < n; j++) begin
      longint term, d;
      if (ssq[j][p]) begin
        d = longint'(sa[j][p]) - longint'(sw[k][j]);
        term = d * d;
      end else begin
        term = longint'(sa[j][p]) * longint'(sw[k][j]);
      end
      acc = acc + term[39:0];
    end
    return acc;
  endfunction

  task automatic send_set(int n, bit uf, int gap_pct, bit garbage);
    for (int j = 0; j < n; j++) begin
      for (int t = 0; t < 4; t++) begin
        bit sent = 0;
        while (!sent) begin
          @(negedge clk);
          if (int'($urandom % 100) < gap_pct) begin
            in_valid = 1'b0;
          end else begin
            in_act   = 16'(sa[j][t]);
            in_wgt   = 16'(sw[t][j]);
            in_bias  = 16'(sb[t]);
            in_first = uf && (j == 0);
            in_last  = (j == n - 1);
            in_sq    = ssq[j][t];
            in_valid = 1'b1;
            if (in_ready) sent = 1;
          end
        end
      end
    end
    @(negedge clk);
    if (garbage) begin
      in_act = 16'($urandom); in_wgt = 16'($urandom); in_bias = 16'($urandom);
      in_first = 1'b1; in_last = 1'b1; in_valid = 1'b1;
    end else begin
      in_valid = 1'b0;
    end
  endtask

  task automatic recv_set(int n, bit uf, int bp_pct, string req);
    int cnt = 0;
    bit hold = 0;
    logic [39:0] hold_data = '0;
    while (cnt < 16) begin
      @(negedge clk);
      out_ready = (int'($urandom % 100) >= bp_pct);
      if (out_valid) check(in_ready == 1'b0, "R11", "in_ready during drain", in_ready, 0);
      if (hold) check(out_valid && out_data == hold_data, "R7", "held result",
                      out_data, hold_data);
      if (out_valid) begin
        if (out_ready) begin
          logic [39:0] e = expect_val(n, uf, cnt / 4, cnt % 4);
          check({out_lane, out_pat} == 4'(cnt), "R6", "result order",
                {out_lane, out_pat}, cnt);
          check(out_data == e, req, $sformatf("lane %0d pat %0d", cnt / 4, cnt % 4),
                out_data, e);
          cnt++;
          hold = 0;
        end else begin
          hold = 1;
          hold_data = out_data;
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b0;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R2", "ready again after drain",
          {in_ready, out_valid}, 2);
  endtask

  task automatic fill_random(int n, int sq_pct);
    for (int j = 0; j < n; j++)
      for (int p = 0; p < 4; p++) begin
        sa[j][p]  = rnd16();
        sw[p][j]  = rnd16();
        ssq[j][p] = (int'($urandom % 100) < sq_pct);
      end
    for (int k = 0; k < 4; k++) sb[k] = rnd16();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // R2 / R3 directed: distinct small values expose lane and pattern swaps
    for (int j = 0; j < 2; j++)
      for (int p = 0; p < 4; p++) begin
        sa[j][p] = (j + 1) * 10 + p;
        sw[p][j] = (j == 0) ? (p + 1) : -(p + 2) * 3;
        ssq[j][p] = 0;
      end
    for (int k = 0; k < 4; k++) sb[k] = 100 * (k + 1);
    send_set(2, 1, 0, 0);
    recv_set(2, 1, 0, "R3");

    // R5: random MAC with bias
    fill_random(8, 0);
    send_set(8, 1, 0, 0);
    recv_set(8, 1, 0, "R5");

    // R4 / R10: mixed modes with input gaps and output stalls
    fill_random(20, 50);
    send_set(20, 1, 30, 0);
    recv_set(20, 1, 40, "R10");

    // R9 / R11: no first marker after a drain, beats offered during drain
    fill_random(5, 100);
    send_set(5, 0, 0, 1);
    recv_set(5, 0, 20, "R9");

    // R3 corner: single input, most negative operands
    for (int p = 0; p < 4; p++) begin
      sa[0][p] = -32768; sw[p][0] = (p == 3) ? 32767 : -32768; ssq[0][p] = 0;
      sb[p] = -32768;
    end
    send_set(1, 1, 0, 0);
    recv_set(1, 1, 0, "R3");

    // R8: 130 maximal squared differences wrap past 2^39
    for (int j = 0; j < 130; j++)
      for (int p = 0; p < 4; p++) begin
        sa[j][p] = 32767; sw[p][j] = -32768; ssq[j][p] = 1;
      end
    send_set(130, 0, 0, 0);
    recv_set(130, 0, 0, "R8");

    // R4 sweep: random sets of random length
    for (int r = 0; r < 3; r++) begin
      int n = 1 + int'($urandom % 40);
      bit uf = $urandom % 2;
      fill_random(n, 30);
      send_set(n, uf, 20, r == 1);
      recv_set(n, uf, 25, "R4");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule